// File: doc/BRIEF.md
# I2C Register-Write Target

This block is a bus target for a two-wire serial control bus. It watches the clock and data lines through a synchroniser running on the system clock. From those lines it recovers the START and STOP framing and the byte stream. When the first byte after a START carries its device address, the block acknowledges it. In a write, the next byte selects a register and every byte after that is stored in a bank of eighty 8-bit registers. The register pointer advances after each byte and folds back to the bottom of the bank when it passes the last register.

The device address has a fixed six-bit upper part (binary 001001). Its lowest bit is taken from a strap input, so two of these blocks can share one bus. The block can pull the data line low, and it does so only to acknowledge. It never holds the clock low. Read transactions get an acknowledge on the address byte and nothing more. A side read port exposes any register to the surrounding logic. The system clock must run at ten or more times the bus clock rate.

Top module: `i2c_regwrite_target`

## Requirements
- R1: A START seen in the middle of a transaction abandons any partly received byte and makes the next eight bits a device-address byte. A START is the data line falling while the clock is high.
- R2: The address byte is sent MSB first with the direction flag in bit 0. It is acknowledged only when bits 7..1 equal binary 001001 followed by the strap input. Any other value leaves the data line released.
- R3: In a write (direction flag 0), the byte after the address is the register selector. It is acknowledged and loaded into the pointer when its bit 7 is 0. When bit 7 is 1 it is not acknowledged, and the rest of the transaction is ignored.
- R4: Each byte that follows the selector in a write is acknowledged and stored in the register the pointer names.
- R5: After each data byte the pointer advances by one. When it is 0x4F it goes to 0x00 instead, so later bytes overwrite the low registers.
- R6: A selector from 0x50 to 0x7F is acknowledged, but data written at those pointer values is dropped. The pointer still advances and passes from 0x7F to 0x00.
- R7: With the direction flag at 1, the matched address byte is acknowledged. Later bytes of that transaction get no acknowledge and change no register.
- R8: After an address mismatch the block drives nothing and changes nothing until the next START or STOP.
- R9: Reset clears every register to 0x00 and releases the data line.
- R10: The acknowledge is driven low from the clock fall that ends the eighth bit until the clock fall that ends the ninth bit. The drive changes only while the synchronised clock is low.
- R11: A STOP releases the data line and returns the block to idle. Bytes clocked after it, before a new START, get no acknowledge and write nothing. A STOP is the data line rising while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sensed at the pin |
| sda_i | input | 1 | Bus data line as sensed at the pin |
| strap_a0 | input | 1 | Lowest bit of the device address |
| sda_drive_low | output | 1 | 1 pulls the data line low (open-drain enable) |
| rd_idx | input | 7 | Register index for the side read port |
| rd_data | output | 8 | Register contents at rd_idx (0 for index 80 and above) |

## Verification
Every 7-bit device address is sent with the strap at 0 and then at 1. The acknowledge must appear for exactly one address in each pass, which separates prefix matching from strap matching. A burst of 80 bytes, each a computed value, fills the whole bank so that a wrong register or a wrong value stands out. Short bursts started at 0x4E and at 0x7E show the two ways the pointer wraps. Further transactions use a selector with bit 7 set, the read direction, the wrong strap, a repeated START after a few stray bits, and bytes clocked after a STOP. Each must leave the bank unchanged apart from the bytes the requirements allow.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int REG_AW      = 7;
    localparam int DATA_W      = 8;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_SUB,
        PH_DATA,
        PH_READ,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } pins_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    function automatic logic [REG_AW-1:0] next_ptr(input logic [REG_AW-1:0] p,
                                                    input logic [REG_AW-1:0] last);
        return (p == last) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/i2cw_bus_sync.sv
module i2cw_bus_sync
    import i2cw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output pins_t   lvl,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_ff[SYNC_STAGES-1];
            sda_q  <= sda_ff[SYNC_STAGES-1];
        end
    end

    always_comb begin
        lvl.scl  = scl_ff[SYNC_STAGES-1];
        lvl.sda  = sda_ff[SYNC_STAGES-1];
        ev.rise  = lvl.scl & ~scl_q;
        ev.fall  = ~lvl.scl & scl_q;
        ev.start = lvl.scl & scl_q & sda_q & ~lvl.sda;
        ev.stop  = lvl.scl & scl_q & ~sda_q & lvl.sda;
    end
endmodule

// File: rtl/i2cw_byte_engine.sv
module i2cw_byte_engine
    import i2cw_pkg::*;
#(
    parameter int          NUM_REGS   = 80,
    parameter logic [5:0]  DEV_PREFIX = 6'b001001
)(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              sda_s,
    input  logic              strap,
    output logic              ack_low,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [REG_AW-1:0] ptr,
    output phase_t            phase
);
    localparam logic [REG_AW-1:0] LAST_IDX  = REG_AW'(NUM_REGS - 1);
    localparam logic [REG_AW:0]   NREG      = (REG_AW+1)'(NUM_REGS);
    localparam logic [3:0]        BYTE_BITS = 4'd8;

    logic [3:0]        cnt;
    logic [DATA_W-1:0] shreg;
    logic              dev_hit;
    logic              ptr_ok;

    assign dev_hit = (shreg[7:1] == {DEV_PREFIX, strap});
    assign ptr_ok  = ({1'b0, ptr} < NREG);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            ack_low <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.start) begin
                phase   <= PH_DEV;
                cnt     <= '0;
                ack_low <= 1'b0;
            end else if (ev.stop) begin
                phase   <= PH_IDLE;
                cnt     <= '0;
                ack_low <= 1'b0;
            end else if (ev.rise && cnt < BYTE_BITS) begin
                shreg <= {shreg[DATA_W-2:0], sda_s};
                cnt   <= cnt + 1'b1;
            end else if (ev.fall && cnt == BYTE_BITS) begin
                cnt <= cnt + 1'b1;
                case (phase)
                    PH_DEV: begin
                        if (dev_hit) begin
                            ack_low <= 1'b1;
                            phase   <= shreg[0] ? PH_READ : PH_SUB;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_SUB: begin
                        if (!shreg[7]) begin
                            ack_low <= 1'b1;
                            ptr     <= shreg[REG_AW-1:0];
                            phase   <= PH_DATA;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_DATA: begin
                        ack_low <= 1'b1;
                        wr_en   <= ptr_ok;
                        wr_idx  <= ptr;
                        wr_data <= shreg;
                        ptr     <= next_ptr(ptr, LAST_IDX);
                    end
                    PH_READ: phase <= PH_SKIP;
                    default: ;
                endcase
            end else if (ev.fall && cnt == BYTE_BITS + 4'd1) begin
                cnt     <= '0;
                ack_low <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2cw_reg_bank.sv
module i2cw_reg_bank
    import i2cw_pkg::*;
#(
    parameter int NUM_REGS = 80
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [REG_AW:0] NREG = (REG_AW+1)'(NUM_REGS);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && wr_idx == REG_AW'(g))
                regs[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if ({1'b0, rd_idx} < NREG && rd_idx == REG_AW'(i))
                rd_data = regs[i];
    end
endmodule

// File: rtl/i2c_regwrite_target.sv
module i2c_regwrite_target
    import i2cw_pkg::*;
#(
    parameter int         NUM_REGS   = 80,
    parameter logic [5:0] DEV_PREFIX = 6'b001001
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic                strap_a0,
    output logic                sda_drive_low,
    input  logic [REG_AW-1:0]   rd_idx,
    output logic [DATA_W-1:0]   rd_data
);
    pins_t             lvl;
    bus_ev_t           ev;
    logic              wr_en;
    logic [REG_AW-1:0] wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [REG_AW-1:0] ptr;
    phase_t            phase;

    i2cw_bus_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .lvl   (lvl),
        .ev    (ev)
    );

    i2cw_byte_engine #(
        .NUM_REGS   (NUM_REGS),
        .DEV_PREFIX (DEV_PREFIX)
    ) u_eng (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .sda_s   (lvl.sda),
        .strap   (strap_a0),
        .ack_low (sda_drive_low),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .ptr     (ptr),
        .phase   (phase)
    );

    i2cw_reg_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker
    import i2cw_pkg::*;
#(
    parameter int NUM_REGS = 80
)(
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              sda_drive_low,
    input logic              stop_ev,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_idx,
    input logic [REG_AW-1:0] ptr,
    input phase_t            phase
);
    localparam logic [REG_AW-1:0] LAST_IDX = REG_AW'(NUM_REGS - 1);
    localparam logic [REG_AW:0]   NREG     = (REG_AW+1)'(NUM_REGS);

    p_drive_on_low_clock_r10: assert property (@(posedge clk) disable iff (rst)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_s);

    p_stop_releases_r11: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_drive_low);

    p_write_in_bank_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ({1'b0, wr_idx} < NREG));

    p_pointer_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == LAST_IDX) |-> (ptr == '0));

    p_skip_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> !sda_drive_low);

    p_reset_release_r9: assert property (@(posedge clk)
        rst |=> !sda_drive_low);
endmodule

bind i2c_regwrite_target i2cw_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_s         (lvl.scl),
    .sda_drive_low (sda_drive_low),
    .stop_ev       (ev.stop),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .ptr           (ptr),
    .phase         (phase)
);

// File: tb/sim_i2c_regwrite_target.sv
`timescale 1ns/1ps
module sim_i2c_regwrite_target;
    localparam int NREGS = 80;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda_low = 1'b0;
    logic       strap = 1'b0;
    logic [6:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       sda_drive_low;
    logic       sda_bus;

    int total = 0;
    int bad = 0;
    logic [7:0] model [NREGS];

    assign sda_bus = !(m_sda_low | sda_drive_low);

    always #2 clk = ~clk;

    i2c_regwrite_target u0 (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (m_scl),
        .sda_i         (sda_bus),
        .strap_a0      (strap),
        .sda_drive_low (sda_drive_low),
        .rd_idx        (rd_idx),
        .rd_data       (rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wq();
        m_scl = 1'b1;     wq();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b0;     wq();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wq();
        m_scl = 1'b1;     wq();
        m_sda_low = 1'b0; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda_low = !b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic early;
        send_bits(b, 8);
        m_sda_low = 1'b0; wq();
        early = sda_drive_low;
        m_scl = 1'b1; wq();
        acked = !sda_bus;
        wq();
        m_scl = 1'b0; wq();
        chk(early == acked, "R10 ack before ninth rise", early, acked);
        chk(!sda_drive_low, "R10 ack released after ninth fall", sda_drive_low, 0);
    endtask

    task automatic compare_bank(input string req);
        for (int i = 0; i < NREGS; i++) begin
            rd_idx = 7'(i); #1;
            chk(rd_data == model[i], req, rd_data, model[i]);
        end
    endtask

    task automatic write_burst(input logic [6:0] sub, input int n, input int seed, input string req);
        logic a;
        int p;
        bus_start();
        send_byte({6'b001001, strap, 1'b0}, a);
        chk(a, {req, " address ack"}, a, 1);
        send_byte({1'b0, sub}, a);
        chk(a, {req, " selector ack"}, a, 1);
        p = sub;
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'(seed + k * 7 + 3);
            send_byte(d, a);
            chk(a, {req, " data ack"}, a, 1);
            if (p < NREGS) model[p] = d;
            p = (p == NREGS - 1) ? 0 : ((p + 1) & 8'h7f);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic a;
        for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        wq();
        // R9: reset state
        chk(!sda_drive_low, "R9 data line released", sda_drive_low, 0);
        compare_bank("R9 register reset value");

        // R2: sweep all addresses for both strap values
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            for (int ad = 0; ad < 128; ad++) begin
                logic exp_ack;
                exp_ack = (7'(ad) == {6'b001001, s[0]});
                bus_start();
                send_byte({7'(ad), 1'b0}, a);
                chk(a == exp_ack, "R2 address match", a, exp_ack);
                bus_stop();
            end
        end
        compare_bank("R2 sweep writes nothing");

        // R4: fill the whole bank
        strap = 1'b1;
        write_burst(7'h00, NREGS, 0, "R4");
        compare_bank("R4 full bank burst");

        // R5: wrap from 0x4F to 0x00
        write_burst(7'h4E, 4, 8'h90, "R5");
        compare_bank("R5 wrap past last register");

        // R6: selectors above the bank
        write_burst(7'h7E, 3, 8'hB0, "R6");
        compare_bank("R6 high pointer wraps to 0");
        write_burst(7'h50, 2, 8'hC0, "R6");
        compare_bank("R6 out-of-bank writes dropped");

        // R3: selector with bit 7 set
        bus_start();
        send_byte(8'h26, a);
        send_byte(8'h85, a);
        chk(!a, "R3 selector bit7 nack", a, 0);
        send_byte(8'h5A, a);
        chk(!a, "R3 data after bad selector nack", a, 0);
        bus_stop();
        compare_bank("R3 no write after bad selector");

        // R7: read direction
        bus_start();
        send_byte(8'h27, a);
        chk(a, "R7 read address ack", a, 1);
        send_byte(8'h00, a);
        chk(!a, "R7 later byte nack", a, 0);
        send_byte(8'h55, a);
        chk(!a, "R7 later byte nack", a, 0);
        bus_stop();
        compare_bank("R7 read writes nothing");

        // R8: wrong strap value
        bus_start();
        send_byte(8'h24, a);
        chk(!a, "R8 mismatch nack", a, 0);
        send_byte(8'h01, a);
        chk(!a, "R8 ignored byte", a, 0);
        send_byte(8'hEE, a);
        chk(!a, "R8 ignored byte", a, 0);
        bus_stop();
        compare_bank("R8 mismatch writes nothing");

        // R1: repeated start after stray bits
        bus_start();
        send_byte(8'h26, a);
        send_byte(8'h10, a);
        send_byte(8'hD0, a);
        model[16] = 8'hD0;
        send_bits(8'hA5, 3);
        bus_start();
        send_byte(8'h26, a);
        chk(a, "R1 address after repeated start", a, 1);
        send_byte(8'h20, a);
        chk(a, "R1 selector after repeated start", a, 1);
        send_byte(8'hE0, a);
        model[32] = 8'hE0;
        bus_stop();
        compare_bank("R1 repeated start");

        // R11: bytes after STOP without START
        bus_stop();
        m_scl = 1'b0; wq();
        send_byte(8'h26, a);
        chk(!a, "R11 no ack after stop", a, 0);
        send_byte(8'h03, a);
        chk(!a, "R11 no ack after stop", a, 0);
        send_byte(8'h77, a);
        chk(!a, "R11 no ack after stop", a, 0);
        bus_stop();
        compare_bank("R11 idle writes nothing");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule